// File: doc/BRIEF.md
# Receive Data Output Conditioner

This block shapes the raw bit coming out of an amplitude demodulator into the clean data level that is handed to a host controller once the receiver is in receiving mode. All decisions are taken on pulses of an extended clock tick (`xtick`), so every interval seen on `data_out` is a whole number of ticks. After each output transition the new level is held for a minimum time. That time is short when the interval that just ended lay inside the programmed bit-check window, and longer when it did not. This suppresses spikes and limits the rate of edges the host must service.

A low level on the output cannot last forever. After a fixed number of ticks the output is forced high, and it stays high until the raw input shows a fresh fall. Outside receiving mode the output rests high. The first tick in receiving mode drives it low as a wake-up edge for the host.

Top module: `rx_data_conditioner`

## Requirements
- R1: `data_out` changes only on the clock cycle after a cycle with `xtick` high, or on the cycle after `rx_en` is seen low; a raw change without a tick leaves it untouched.
- R2: The edge-to-edge interval (ee) is the number of ticks from one output transition to the next. If ee satisfies `lim_min` <= ee < `lim_max`, including ee equal to `lim_min`, the new level is held for 9 ticks, so the next transition comes no earlier than 9 ticks later.
- R3: If ee is below `lim_min`, or at or above `lim_max`, the new level is held for 11 ticks.
- R4: Once `data_out` has been low for 131 ticks it is forced high on that tick, even though `raw_bit` stays low.
- R5: On the first tick after `rx_en` goes high, `data_out` falls regardless of `raw_bit`, and that low level is held for 11 ticks.
- R6: While `rx_en` is low, `data_out` is high, and it returns high on the cycle after `rx_en` is sampled low, whatever the ticks and `raw_bit` do.
- R7: Raw levels during a hold are ignored. On the first tick after the hold ends, the output toggles only if `raw_bit` then differs from it, so a pulse that is over before the hold ends leaves no trace.
- R8: The ee count saturates at 63, so an interval longer than 63 ticks is classed as 63. With `lim_max` = 63 it falls outside the window and gets an 11-tick hold.
- R9: After a forced high (R4), `data_out` stays high while `raw_bit` stays low. It falls again only after `raw_bit` has been seen high on a tick and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtick | input | 1 | One-cycle pulse marking an extended clock period |
| raw_bit | input | 1 | Raw demodulator bit, synchronous to `clk` |
| lim_min | input | 6 | Lower bound of the bit-check window, in ticks, inclusive |
| lim_max | input | 6 | Upper bound of the bit-check window, in ticks, exclusive |
| rx_en | input | 1 | High while the receiver is in receiving mode |
| data_out | output | 1 | Conditioned data level, high when idle |

## Verification
Three decisions meet on the tick where a hold expires. A raw level left pending during the hold is judged on that tick. On the same tick, the interval that just ended picks the length of the next hold. The bench provokes this by placing transitions exactly at ee equal to `lim_min`, at ee equal to `lim_max`, and at a saturated count, and by keeping a changed raw level pending through a hold. It then confirms that the toggle lands on the first free tick and that the next transition lands exactly 9 or 11 ticks later. A second meeting point is the tick where the low-time cap fires. There the output must rise while `raw_bit` is still low, and it must then refuse to fall until the raw input has been seen high.

// File: rtl/rxdc_pkg.sv
// Shared constants for the receive data conditioner.
// Assumes: all timing counts are in extended-clock ticks.
package rxdc_pkg;
    typedef enum logic {
        HOLD_LONG  = 1'b0,
        HOLD_SHORT = 1'b1
    } hold_cls_e;
endpackage

// File: rtl/rxdc_interval.sv
// Counts ticks since the last output transition and classifies the interval
// that would close if a transition happened on the current tick.
// Assumes: edge_now is only meaningful while tick is high.
module rxdc_interval
    import rxdc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             edge_now,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    output hold_cls_e        cls
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ee_now;

    // interval length if it ended on this tick, saturating
    always_comb begin
        ee_now = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        cls    = ((ee_now >= lim_lo) && (ee_now < lim_hi)) ? HOLD_SHORT : HOLD_LONG;
    end

    // tick counter restarted by each transition
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= edge_now ? '0 : ee_now;
        end
    end

    // R8
    interval_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !edge_now && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/rxdc_hold.sv
// Minimum-hold timer started at every output transition.
// Assumes: both hold lengths are at least 2 ticks.
module rxdc_hold
    import rxdc_pkg::*;
#(
    parameter int HOLD_IN  = 9,
    parameter int HOLD_OUT = 11
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  logic      load,
    input  hold_cls_e cls,
    output logic      busy
);
    localparam int HMAX = (HOLD_IN > HOLD_OUT) ? HOLD_IN : HOLD_OUT;
    localparam int HW   = $clog2(HMAX + 1);
    localparam logic [HW-1:0] SHORT_V = HW'(HOLD_IN - 1);
    localparam logic [HW-1:0] LONG_V  = HW'(HOLD_OUT - 1);

    logic [HW-1:0] rem_q;

    // remaining blocked ticks after the transition tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q <= '0;
        end else if (tick) begin
            if (load) begin
                rem_q <= (cls == HOLD_SHORT) ? SHORT_V : LONG_V;
            end else if (rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign busy = (rem_q != '0);

    // R2 R3
    hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load && !clr) |=> busy);
endmodule

// File: rtl/rxdc_lowcap.sv
// Measures how long the output has been low and flags the cap tick.
// Assumes: low_now reflects the registered output level.
module rxdc_lowcap #(
    parameter int LOW_CAP = 131
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic low_now,
    output logic expire
);
    localparam int LW = $clog2(LOW_CAP);
    localparam logic [LW-1:0] LAST_V = LW'(LOW_CAP - 1);

    logic [LW-1:0] cnt_q;

    // ticks elapsed since the output went low
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !low_now) begin
            cnt_q <= '0;
        end else if (tick && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = tick && low_now && (cnt_q == LAST_V);

    // R4
    lowcap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V);
endmodule

// File: rtl/rx_data_conditioner.sv
// Conditions the raw demodulated bit into the host data level during
// receiving mode: tick-aligned changes, window-dependent minimum hold,
// low-time cap with re-arm lock, and a wake-up fall on entry.
// Assumes: raw_bit and rx_en are already synchronous to clk.
module rx_data_conditioner
    import rxdc_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int HOLD_IN  = 9,
    parameter int HOLD_OUT = 11,
    parameter int LOW_CAP  = 131
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtick,
    input  logic             raw_bit,
    input  logic [CNT_W-1:0] lim_min,
    input  logic [CNT_W-1:0] lim_max,
    input  logic             rx_en,
    output logic             data_out
);
    logic      out_q;
    logic      woke_q;
    logic      lock_q;
    logic      run;
    logic      wake;
    logic      live;
    logic      force_hi;
    logic      toggle;
    logic      unlock;
    logic      edge_now;
    logic      hold_busy;
    logic      cap_expire;
    hold_cls_e iv_cls;
    hold_cls_e hold_cls;

    // decisions taken on the current tick
    always_comb begin
        run      = rx_en && xtick;
        wake     = run && !woke_q;
        live     = run && woke_q;
        force_hi = live && cap_expire;
        toggle   = live && !force_hi && !hold_busy && !lock_q && (raw_bit != out_q);
        unlock   = live && !hold_busy && lock_q && raw_bit;
        edge_now = wake || force_hi || toggle;
        hold_cls = wake ? HOLD_LONG : iv_cls;
    end

    rxdc_interval #(.CNT_W(CNT_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_en),
        .tick     (run),
        .edge_now (edge_now),
        .lim_lo   (lim_min),
        .lim_hi   (lim_max),
        .cls      (iv_cls)
    );

    rxdc_hold #(.HOLD_IN(HOLD_IN), .HOLD_OUT(HOLD_OUT)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rx_en),
        .tick  (run),
        .load  (edge_now),
        .cls   (hold_cls),
        .busy  (hold_busy)
    );

    rxdc_lowcap #(.LOW_CAP(LOW_CAP)) u_lowcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!rx_en),
        .tick    (run),
        .low_now (!out_q),
        .expire  (cap_expire)
    );

    // output level, wake flag and post-cap lock
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            out_q  <= 1'b1;
            woke_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (wake) begin
                out_q  <= 1'b0;
                woke_q <= 1'b1;
            end
            if (force_hi) begin
                out_q  <= 1'b1;
                lock_q <= 1'b1;
            end
            if (toggle) begin
                out_q <= ~out_q;
            end
            if (unlock) begin
                lock_q <= 1'b0;
            end
        end
    end

    assign data_out = out_q;

    // R1
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xtick && rx_en) |=> $stable(data_out));

    // R6
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> data_out);

    // R2 R3 R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xtick && rx_en && woke_q && hold_busy && !cap_expire) |=> $stable(data_out));

    // R4
    cap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && cap_expire && woke_q) |=> data_out);

    // R9
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && lock_q && !raw_bit && !cap_expire) |=> data_out);
endmodule

// File: tb/rx_data_conditioner_bench.sv
module rx_data_conditioner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtick = 1'b0;
    logic       raw_bit = 1'b1;
    logic [5:0] lim_min = 6'd14;
    logic [5:0] lim_max = 6'd24;
    logic       rx_en = 1'b0;
    logic       data_out;
    int         checks = 0;
    int         failures = 0;

    always #4 clk = ~clk;

    rx_data_conditioner u_rx_data_conditioner (
        .clk      (clk),
        .rst_n    (rst_n),
        .xtick    (xtick),
        .raw_bit  (raw_bit),
        .lim_min  (lim_min),
        .lim_max  (lim_max),
        .rx_en    (rx_en),
        .data_out (data_out)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (data_out !== exp) begin
            failures++;
            $display("FAIL %s: data_out=%b expected=%b at %0t", req, data_out, exp, $time);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) xtick = 1'b1;
        @(negedge clk) xtick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input logic v);
        raw_bit = v;
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic t_reset_idle();
        check(1'b1, "R6");
        ticks(5, 1'b0);
        check(1'b1, "R6");
    endtask

    task automatic t_wake();
        rx_en = 1'b1;
        ticks(1, 1'b1);
        check(1'b0, "R5");
        ticks(10, 1'b1);
        check(1'b0, "R5");
        ticks(1, 1'b1);
        check(1'b1, "R5");
    endtask

    task automatic t_lim_min_edge();
        ticks(13, 1'b1);
        raw_bit = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b1, "R1");
        ticks(1, 1'b0);
        check(1'b0, "R2");
        ticks(8, 1'b1);
        check(1'b0, "R2");
        ticks(1, 1'b1);
        check(1'b1, "R2");
    endtask

    task automatic t_lim_max_edge();
        ticks(23, 1'b1);
        ticks(1, 1'b0);
        check(1'b0, "R3");
        ticks(10, 1'b1);
        check(1'b0, "R3");
        ticks(1, 1'b1);
        check(1'b1, "R3");
    endtask

    task automatic t_hold_pulse();
        ticks(3, 1'b0);
        ticks(7, 1'b1);
        check(1'b1, "R7");
        ticks(20, 1'b1);
        check(1'b1, "R7");
    endtask

    task automatic t_saturate();
        lim_min = 6'd0;
        lim_max = 6'd63;
        ticks(70, 1'b1);
        ticks(1, 1'b0);
        check(1'b0, "R8");
        ticks(10, 1'b1);
        check(1'b0, "R8");
        ticks(1, 1'b1);
        check(1'b1, "R8");
        lim_min = 6'd14;
        lim_max = 6'd24;
    endtask

    task automatic t_low_cap();
        ticks(20, 1'b1);
        ticks(1, 1'b0);
        check(1'b0, "R4");
        ticks(130, 1'b0);
        check(1'b0, "R4");
        ticks(1, 1'b0);
        check(1'b1, "R4");
        ticks(40, 1'b0);
        check(1'b1, "R9");
        ticks(3, 1'b1);
        check(1'b1, "R9");
        ticks(1, 1'b0);
        check(1'b0, "R9");
    endtask

    task automatic t_exit();
        @(negedge clk) rx_en = 1'b0;
        raw_bit = 1'b0;
        @(negedge clk);
        check(1'b1, "R6");
        ticks(4, 1'b0);
        check(1'b1, "R6");
        rx_en = 1'b1;
        ticks(1, 1'b0);
        check(1'b0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_wake();
        t_lim_min_edge();
        t_lim_max_edge();
        t_hold_pulse();
        t_saturate();
        t_low_cap();
        t_exit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule